// File: doc/BRIEF.md
# Sixteen-Bit Integer ALU

A purely combinational arithmetic-logic unit for a small integer datapath. Two operands, X and Y, and a 3-bit operation code select one of eight functions: bitwise OR, bitwise AND, addition, subtraction, logical left shift, logical right shift, arithmetic right shift and signed set-less-than. The selected function's value appears on the result bus.

Three status outputs accompany the result. The unsigned overflow flag is qualified to addition. The signed overflow flag is qualified to addition and subtraction. The equality flag compares the operands bit for bit under every operation code. Shifts take their distance from the low bits of Y only. Set-less-than answers correctly even when the internal X minus Y wraps.

The block has no state. Every output settles from the current inputs alone, so it can sit directly in an execute stage between pipeline registers.

Top module: `int_alu`

## Requirements
- R1: Operation code 000 gives X OR Y and code 001 gives X AND Y, bit by bit.
- R2: Operation code 010 gives X plus Y, wrapped modulo 2^16.
- R3: Operation code 011 gives X minus Y, wrapped modulo 2^16.
- R4: The unsigned overflow flag is 1 only when the code is 010 and the unsigned sum carries out of bit 15. It is 0 under every other code, including 011.
- R5: The signed overflow flag is 1 only when the code is 010 or 011 and the two's-complement result does not fit in 16 bits. It is 0 under every other code.
- R6: Operation code 100 shifts X left by Y[3:0] with zeros entering at the bottom. Under all three shift codes, Y[15:4] has no effect on the result.
- R7: Operation code 101 shifts X right by Y[3:0] with zeros entering at the top.
- R8: Operation code 110 shifts X right by Y[3:0] with copies of X[15] entering at the top.
- R9: Operation code 111 gives 16'd1 when X is less than Y as signed values, and 16'd0 otherwise. This holds even when X minus Y overflows.
- R10: The equality flag is 1 exactly when X and Y are identical. It is produced under every operation code.
- R11: All outputs are a pure function of the present inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_x_i | input | 16 | First operand X |
| opnd_y_i | input | 16 | Second operand Y; its low 4 bits are the shift distance |
| op_sel_i | input | 3 | Operation code |
| result_o | output | 16 | Value of the selected function |
| ovf_signed_o | output | 1 | Two's-complement overflow on add or subtract |
| ovf_unsigned_o | output | 1 | Carry out of the top bit on add |
| equal_o | output | 1 | Operands identical |

## Verification
The bench builds the block with its default width of 16, which gives a 4-bit shift distance. At this width the exact boundaries are the vectors themselves: 0x7FFF plus 1, 0xFFFF plus 1, 0x8000 minus 1, shifts by 0 and by 15, and set-less-than of 0x8000 against 0x7FFF. Other directed vectors set Y's upper bits while the shift distance is zero or one, which exposes any leak of those bits into the shifter. Random operands under every operation code then cover the remaining combinations of signs and carries.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [2:0] {
    OP_OR  = 3'b000,
    OP_AND = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b011,
    OP_SLL = 3'b100,
    OP_SRL = 3'b101,
    OP_SRA = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

endpackage

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] and_o,
  output logic             same_o
);

  logic [WIDTH-1:0] diff_bits;

  always_comb begin
    or_o      = a_i | b_i;
    and_o     = a_i & b_i;
    diff_bits = a_i ^ b_i;
    same_o    = ~(|diff_bits);
  end

  // R10: identical operands give equal OR and AND images
  always_comb begin
    if (same_o) begin
      p_same_or_and_r10: assert (or_o == and_o)
        else $error("identical operands but OR and AND differ");
    end
  end

endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_en_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             sovf_o,
  output logic             less_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide_sum;

  always_comb begin
    b_eff    = sub_en_i ? ~b_i : b_i;
    wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_en_i};
    sum_o    = wide_sum[MSB:0];
    carry_o  = wide_sum[WIDTH];
    // operands of equal sign feeding the adder, result of the other sign
    sovf_o   = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
    // sign of the difference, corrected when the difference overflowed
    less_o   = sum_o[MSB] ^ sovf_o;
  end

  // R4: a carry out of an addition means the wrapped sum is below operand a
  always_comb begin
    if (!sub_en_i && carry_o) begin
      p_carry_wraps_r4: assert (sum_o < a_i)
        else $error("carry without wrap");
    end
  end

  // R9: when the difference is exact, its sign is the comparison answer
  always_comb begin
    if (sub_en_i && !sovf_o) begin
      p_less_exact_r9: assert (less_o == sum_o[MSB])
        else $error("less-than disagrees with exact difference sign");
    end
  end

endmodule

// File: rtl/int_alu_shifter.sv
module int_alu_shifter #(
  parameter int WIDTH   = 16,
  parameter int SHAMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]   val_i,
  input  logic [SHAMT_W-1:0] amt_i,
  output logic [WIDTH-1:0]   sll_o,
  output logic [WIDTH-1:0]   srl_o,
  output logic [WIDTH-1:0]   sra_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] lft_st [SHAMT_W+1];
  logic [WIDTH-1:0] rz_st  [SHAMT_W+1];
  logic [WIDTH-1:0] rs_st  [SHAMT_W+1];
  logic             sign_fill;

  assign sign_fill = val_i[MSB];
  assign lft_st[0] = val_i;
  assign rz_st[0]  = val_i;
  assign rs_st[0]  = val_i;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign lft_st[k+1] = amt_i[k] ? {lft_st[k][MSB-STEP:0], {STEP{1'b0}}} : lft_st[k];
    assign rz_st[k+1]  = amt_i[k] ? {{STEP{1'b0}}, rz_st[k][MSB:STEP]} : rz_st[k];
    assign rs_st[k+1]  = amt_i[k] ? {{STEP{sign_fill}}, rs_st[k][MSB:STEP]} : rs_st[k];
  end

  assign sll_o = lft_st[SHAMT_W];
  assign srl_o = rz_st[SHAMT_W];
  assign sra_o = rs_st[SHAMT_W];

  // R8: with a clear sign bit the arithmetic and logical right shifts agree
  always_comb begin
    if (!val_i[MSB]) begin
      p_sra_pos_r8: assert (sra_o == srl_o)
        else $error("sra and srl differ on non-negative value");
    end
  end

  // R7: logical right and left shifts by zero both return the value
  always_comb begin
    if (amt_i == '0) begin
      p_zero_shift_r7: assert (srl_o == val_i && sll_o == val_i)
        else $error("shift by zero changed the value");
    end
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int SHAMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opnd_x_i,
  input  logic [WIDTH-1:0] opnd_y_i,
  input  logic [2:0]       op_sel_i,
  output logic [WIDTH-1:0] result_o,
  output logic             ovf_signed_o,
  output logic             ovf_unsigned_o,
  output logic             equal_o
);

  alu_op_e          op;
  logic [WIDTH-1:0] or_val, and_val, sum_val, sll_val, srl_val, sra_val;
  logic             same, carry, sovf, less, sub_en;

  assign op     = alu_op_e'(op_sel_i);
  assign sub_en = (op == OP_SUB) || (op == OP_SLT);

  int_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i    (opnd_x_i),
    .b_i    (opnd_y_i),
    .or_o   (or_val),
    .and_o  (and_val),
    .same_o (same)
  );

  int_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i      (opnd_x_i),
    .b_i      (opnd_y_i),
    .sub_en_i (sub_en),
    .sum_o    (sum_val),
    .carry_o  (carry),
    .sovf_o   (sovf),
    .less_o   (less)
  );

  int_alu_shifter #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_shift (
    .val_i (opnd_x_i),
    .amt_i (opnd_y_i[SHAMT_W-1:0]),
    .sll_o (sll_val),
    .srl_o (srl_val),
    .sra_o (sra_val)
  );

  always_comb begin
    unique case (op)
      OP_OR:   result_o = or_val;
      OP_AND:  result_o = and_val;
      OP_ADD:  result_o = sum_val;
      OP_SUB:  result_o = sum_val;
      OP_SLL:  result_o = sll_val;
      OP_SRL:  result_o = srl_val;
      OP_SRA:  result_o = sra_val;
      OP_SLT:  result_o = {{(WIDTH-1){1'b0}}, less};
      default: result_o = '0;
    endcase
    ovf_unsigned_o = (op == OP_ADD) && carry;
    ovf_signed_o   = ((op == OP_ADD) || (op == OP_SUB)) && sovf;
    equal_o        = same;
  end

  // R4: unsigned overflow only under add
  always_comb begin
    if (op != OP_ADD) begin
      p_uovf_add_only_r4: assert (!ovf_unsigned_o)
        else $error("unsigned overflow outside add");
    end
  end

  // R5: signed overflow only under add or subtract
  always_comb begin
    if (op != OP_ADD && op != OP_SUB) begin
      p_sovf_qual_r5: assert (!ovf_signed_o)
        else $error("signed overflow outside add/sub");
    end
  end

  // R9: set-less-than yields 0 or 1 only
  always_comb begin
    if (op == OP_SLT) begin
      p_slt_bool_r9: assert (result_o[WIDTH-1:1] == '0)
        else $error("slt result not boolean");
    end
  end

  // R10 with R3: identical operands subtract to zero without overflow
  always_comb begin
    if (equal_o && op == OP_SUB) begin
      p_eq_sub_zero_r10: assert (result_o == '0 && !ovf_signed_o)
        else $error("equal operands but nonzero difference");
    end
  end

  // R6: a zero shift distance leaves X untouched whatever Y's upper bits
  always_comb begin
    if (op == OP_SLL && opnd_y_i[SHAMT_W-1:0] == '0) begin
      p_sll_zero_r6: assert (result_o == opnd_x_i)
        else $error("sll by zero altered X");
    end
  end

endmodule

// File: tb/int_alu_test.sv
module int_alu_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;
  localparam int NRAND = 400;

  // {op[2:0], x[15:0], y[15:0], result[15:0], sovf, uovf, eq}
  localparam logic [53:0] VEC [NVEC] = '{
    {3'b000, 16'hF0F0, 16'h0F0F, 16'hFFFF, 3'b000},
    {3'b001, 16'hF0F0, 16'hFF00, 16'hF000, 3'b000},
    {3'b010, 16'h7FFF, 16'h0001, 16'h8000, 3'b100},
    {3'b010, 16'hFFFF, 16'h0001, 16'h0000, 3'b010},
    {3'b010, 16'h8000, 16'h8000, 16'h0000, 3'b111},
    {3'b011, 16'h8000, 16'h0001, 16'h7FFF, 3'b100},
    {3'b011, 16'h0000, 16'h0001, 16'hFFFF, 3'b000},
    {3'b100, 16'h0001, 16'h000F, 16'h8000, 3'b000},
    {3'b100, 16'h1234, 16'hFFF0, 16'h1234, 3'b000},
    {3'b101, 16'h8000, 16'h000F, 16'h0001, 3'b000},
    {3'b101, 16'h8000, 16'h0010, 16'h8000, 3'b000},
    {3'b110, 16'h8000, 16'h000F, 16'hFFFF, 3'b000},
    {3'b110, 16'h4000, 16'h0011, 16'h2000, 3'b000},
    {3'b111, 16'h8000, 16'h7FFF, 16'h0001, 3'b000},
    {3'b111, 16'h7FFF, 16'h8000, 16'h0000, 3'b000},
    {3'b111, 16'h0005, 16'h0005, 16'h0000, 3'b001},
    {3'b000, 16'h00AA, 16'h00AA, 16'h00AA, 3'b001}
  };

  logic        clk;
  logic [15:0] x, y, res;
  logic [2:0]  sel;
  logic        sovf, uovf, eq;
  int          checks, errors;
  bit          done;

  int_alu uut (
    .opnd_x_i       (x),
    .opnd_y_i       (y),
    .op_sel_i       (sel),
    .result_o       (res),
    .ovf_signed_o   (sovf),
    .ovf_unsigned_o (uovf),
    .equal_o        (eq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tag_of(input logic [2:0] s);
    case (s)
      3'b000, 3'b001: return "R1";
      3'b010: return "R2";
      3'b011: return "R3";
      3'b100: return "R6";
      3'b101: return "R7";
      3'b110: return "R8";
      default: return "R9";
    endcase
  endfunction

  // expected {result, sovf, uovf, eq} from the requirements
  function automatic logic [18:0] model(input logic [2:0] s,
                                        input logic [15:0] a, input logic [15:0] b);
    logic [16:0] w;
    logic [15:0] r;
    logic        so, uo;
    so = 1'b0; uo = 1'b0; r = '0;
    case (s)
      3'b000: r = a | b;
      3'b001: r = a & b;
      3'b010: begin
        w  = {1'b0, a} + {1'b0, b};
        r  = w[15:0];
        uo = w[16];
        so = ($signed(a) + $signed(b) > 32767) || ($signed(a) + $signed(b) < -32768);
      end
      3'b011: begin
        r  = a - b;
        so = ($signed(a) - $signed(b) > 32767) || ($signed(a) - $signed(b) < -32768);
      end
      3'b100: r = a << b[3:0];
      3'b101: r = a >> b[3:0];
      3'b110: r = $unsigned($signed(a) >>> b[3:0]);
      default: r = ($signed(a) < $signed(b)) ? 16'd1 : 16'd0;
    endcase
    return {r, so, uo, (a == b)};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h (op %b x %h y %h)",
               tag, what, got, exp, sel, x, y);
    end
  endtask

  task automatic apply_and_check(input logic [2:0] s, input logic [15:0] a,
                                 input logic [15:0] b, input logic [18:0] exp);
    @(posedge clk);
    sel = s; x = a; y = b;
    #(CLK_PERIOD/4);
    check(tag_of(s), "result", res, exp[18:3]);
    check("R5", "signed overflow", {15'd0, sovf}, {15'd0, exp[2]});
    check("R4", "unsigned overflow", {15'd0, uovf}, {15'd0, exp[1]});
    check("R10", "equal", {15'd0, eq}, {15'd0, exp[0]});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    sel = '0; x = '0; y = '0;

    // R11: all-zero inputs settle to a defined output
    @(posedge clk);
    #(CLK_PERIOD/4);
    check("R11", "idle result", res, 16'h0000);
    check("R10", "idle equal", {15'd0, eq}, 16'd1);

    // table of directed vectors; R6 rows set Y upper bits with small distances
    for (int i = 0; i < NVEC; i++) begin
      apply_and_check(VEC[i][53:51], VEC[i][50:35], VEC[i][34:19], VEC[i][18:0]);
    end

    // R10: equality reported under every operation code
    for (int s = 0; s < 8; s++) begin
      apply_and_check(3'(s), 16'hBEEF, 16'hBEEF, model(3'(s), 16'hBEEF, 16'hBEEF));
    end

    // R6: upper Y bits ignored under each shift code
    for (int s = 4; s < 7; s++) begin
      apply_and_check(3'(s), 16'h9A5C, 16'hABC3, model(3'(s), 16'h9A5C, 16'h0003));
    end

    // random operands under every code, R2 R3 R9 included
    for (int n = 0; n < NRAND; n++) begin
      logic [15:0] a, b;
      logic [2:0]  s;
      a = 16'($urandom);
      b = 16'($urandom);
      s = 3'(n % 8);
      if (n % 17 == 0) b = a;
      apply_and_check(s, a, b, model(s, a, b));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule